// File: doc/BRIEF.md
# Programmable Countdown Timer

The block is an 8-bit binary down-counter for a real-time-clock style design. A clock divider elsewhere supplies four single-cycle tick enables at different rates. A two-bit source field picks one of them, and a run bit gates it onto the counter. Each selected tick takes one from the count. When a tick takes the count from one to zero, three things happen on that edge:

- the counter reloads the last value software wrote,
- a sticky timeout flag is set,
- the interrupt output goes high if interrupts are enabled.

With a value n loaded, the time between timeouts is n divided by the rate of the chosen source.

All configuration goes through one plain register write port. Address 0 holds the count value, address 1 holds the timer control, and address 2 holds the flag and the interrupt enable. Writes are accepted on any cycle and there is no back-pressure. No data stream crosses the block edge, so the port has no valid/ready handshake. The count output is the live counter. It is not frozen for reading, so a reader that samples it from another clock domain has to read it twice and compare the two values.

Top module: `cdt_timer`

## Requirements
- R1: After reset the live count is 0, the flag and the interrupt are 0, and the timer is stopped (run = 0, source 0), so ticks have no effect.
- R2: A write to address 0 sets the live count and the reload value to the written byte on that clock edge, whether or not the timer runs. It wins over a tick in the same cycle.
- R3: While running, every cycle in which the selected tick is high and the count is above 1 decrements the count by exactly one. The count output shows each new value.
- R4: While stopped (address 1 bit 0 = 0), ticks on any input leave the count unchanged.
- R5: Address 1 bits 2:1 select the source: value s makes tick input s the only one that counts. Control writes take effect from the next cycle.
- R6: A selected tick while the count is 1 reloads the count from the last written value and sets the flag on the same edge. The period is therefore n selected ticks for any n from 1 to 255.
- R7: A count of 0 holds under ticks and never sets the flag.
- R8: The flag is sticky. Writing address 2 with bit 0 = 0 clears it, and writing bit 0 = 1 leaves it as it is. A timeout in the same cycle as a clearing write leaves the flag set.
- R9: The interrupt output is high exactly when the flag and the interrupt enable (address 2 bit 1) are both set.
- R10: Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register address (0 count, 1 control, 2 status) |
| reg_wr_data | input | 8 | Register write data |
| tick_en | input | 4 | Tick enables from the clock divider, one per source |
| count_o | output | 8 | Live counter value |
| flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Every load value from 1 to 255 is swept, and the number of ticks before the flag rises is compared with n. A design that reloads one tick early or late, or that sets the flag on the 0-to-reload step, shows a period of n-1 or n+1. Each source select is driven with a pseudo-random pattern on all four tick inputs, which catches a swapped or mis-decoded selector and ticks leaking from an unselected source. A write colliding with a tick is tested. So is a clearing write colliding with a timeout, where a design with the wrong priority would lose a load or a timeout event. A zero load under ticks is tested too, where a wrong design would wrap to 255 or raise a spurious flag.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int CDT_ADDR_W = 2;
  localparam logic [CDT_ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [CDT_ADDR_W-1:0] ADDR_CTRL  = 2'd1;
  localparam logic [CDT_ADDR_W-1:0] ADDR_STAT  = 2'd2;
  // control register field positions
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_SRC_LSB = 1;
  // status register field positions
  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_IE_BIT   = 1;
endpackage

// File: rtl/cdt_tick_sel.sv
module cdt_tick_sel #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] tick_en,
  input  logic [SEL_W-1:0]   sel,
  input  logic               run,
  output logic               step
);
  logic [NUM_SRC-1:0] hit;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = tick_en[g] && (sel == SEL_W'(g));
  end
  assign step = run && (|hit);
endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] reload_q;
  logic             advance;

  assign advance = step && !load && (cnt_q != ZERO);
  assign expire  = advance && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= ZERO;
      reload_q <= ZERO;
    end else if (load) begin
      cnt_q    <= load_val;
      reload_q <= load_val;
    end else if (expire) begin
      cnt_q <= reload_q;
    end else if (advance) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt_q));
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q == ONE) |=> cnt_q == $past(reload_q));
  assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == ZERO) |=> cnt_q == ZERO);
endmodule

// File: rtl/cdt_flag_irq.sv
module cdt_flag_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic wr_stat,
  input  logic wr_flag_bit,
  input  logic wr_ie_bit,
  output logic flag_q,
  output logic irq
);
  logic ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (expire)                      flag_q <= 1'b1;
      else if (wr_stat && !wr_flag_bit) flag_q <= 1'b0;
      if (wr_stat) ie_q <= wr_ie_bit;
    end
  end

  assign irq = flag_q && ie_q;

  assert_set_on_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_stat && !wr_flag_bit)) |=> flag_q);
  assert_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(expire));
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NUM_SRC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [CDT_ADDR_W-1:0] reg_wr_addr,
  input  logic [CNT_W-1:0]      reg_wr_data,
  input  logic [NUM_SRC-1:0]    tick_en,
  output logic [CNT_W-1:0]      count_o,
  output logic                  flag_o,
  output logic                  irq_o
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             wr_count, wr_ctrl, wr_stat;
  logic             run_q;
  logic [SEL_W-1:0] src_q;
  logic             step, expire;

  assign wr_count = reg_wr_en && (reg_wr_addr == ADDR_COUNT);
  assign wr_ctrl  = reg_wr_en && (reg_wr_addr == ADDR_CTRL);
  assign wr_stat  = reg_wr_en && (reg_wr_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      src_q <= '0;
    end else if (wr_ctrl) begin
      run_q <= reg_wr_data[CTRL_RUN_BIT];
      src_q <= reg_wr_data[CTRL_SRC_LSB +: SEL_W];
    end
  end

  cdt_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .tick_en (tick_en),
    .sel     (src_q),
    .run     (run_q),
    .step    (step)
  );

  cdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_count),
    .load_val (reg_wr_data),
    .step     (step),
    .cnt_q    (count_o),
    .expire   (expire)
  );

  cdt_flag_irq u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire      (expire),
    .wr_stat     (wr_stat),
    .wr_flag_bit (reg_wr_data[STAT_FLAG_BIT]),
    .wr_ie_bit   (reg_wr_data[STAT_IE_BIT]),
    .flag_q      (flag_o),
    .irq         (irq_o)
  );

  assert_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !step);
  assert_ignore_addr3_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == 2'd3) |=> ($stable(run_q) && $stable(src_q)));
endmodule

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_wr_addr = '0;
  logic [7:0] reg_wr_data = '0;
  logic [3:0] tick_en = '0;
  logic [7:0] count_o;
  logic       flag_o, irq_o;

  always #10 clk = ~clk;

  cdt_timer dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  // bench model state, built from the requirements
  bit [7:0] m_cnt = 0, m_rel = 0;
  bit m_flag = 0, m_ie = 0, m_run = 0, m_exp = 0;
  bit [1:0] m_sel = 0;
  bit [15:0] lf = 16'hACE1;

  function automatic bit [15:0] lfsr(bit [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // entered at a falling edge; drives one cycle and compares at the next falling edge
  task automatic cyc(string req, bit we, bit [1:0] a, bit [7:0] d, bit [3:0] t);
    bit step;
    reg_wr_en = we; reg_wr_addr = a; reg_wr_data = d; tick_en = t;
    step  = m_run && t[m_sel];
    m_exp = 0;
    if (we && a == 2'd0) begin m_cnt = d; m_rel = d; end
    else if (step && m_cnt == 8'd1) begin m_cnt = m_rel; m_exp = 1; end
    else if (step && m_cnt != 8'd0) m_cnt = m_cnt - 8'd1;
    if (m_exp) m_flag = 1;
    else if (we && a == 2'd2 && !d[0]) m_flag = 0;
    if (we && a == 2'd2) m_ie = d[1];
    if (we && a == 2'd1) begin m_run = d[0]; m_sel = d[2:1]; end
    @(negedge clk);
    chk(req, "count", count_o, m_cnt);
    chk(req, "flag", flag_o, m_flag);
    chk(req, "irq", irq_o, m_flag && m_ie);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got 0 expected 1 completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "count", count_o, 0);
    chk("R1", "flag", flag_o, 0);
    chk("R1", "irq", irq_o, 0);
    for (int i = 0; i < 5; i++) cyc("R1", 0, 0, 0, 4'hF);

    // R2: loads while stopped
    cyc("R2", 1, 0, 8'd37, 0);
    cyc("R2", 1, 0, 8'd255, 4'hF);
    cyc("R2", 1, 0, 8'd0, 0);
    // R4: stopped, ticks ignored
    cyc("R4", 1, 0, 8'd12, 0);
    for (int i = 0; i < 20; i++) cyc("R4", 0, 0, 0, 4'hF);
    // R3: decrement, source 0 each cycle
    cyc("R3", 1, 1, 8'h01, 0);
    for (int i = 0; i < 8; i++) cyc("R3", 0, 0, 0, 4'h1);
    // R2: load collides with tick while running
    cyc("R2", 1, 0, 8'd50, 4'h1);
    cyc("R2", 0, 0, 0, 4'h1);
    chk("R2", "after collision", count_o, 49);

    // R5: each source select with random tick patterns on all inputs
    for (int s = 0; s < 4; s++) begin
      cyc("R5", 1, 1, 8'((s << 1) | 1), 0);
      cyc("R5", 1, 0, 8'd9, 0);
      for (int i = 0; i < 60; i++) begin
        lf = lfsr(lf);
        cyc("R5", 0, 0, 0, lf[3:0]);
      end
    end

    // R6: every period length 1..255 with source 0
    cyc("R6", 1, 1, 8'h01, 0);
    for (int n = 1; n < 256; n++) begin
      int k;
      cyc("R6", 1, 2, 8'h00, 0);
      cyc("R6", 1, 0, 8'(n), 0);
      k = 0;
      do begin cyc("R6", 0, 0, 0, 4'h1); k++; end while (!m_exp && k < 300);
      chk("R6", "period ticks", k, n);
      chk("R6", "reloaded count", count_o, n);
    end

    // R7: zero count holds
    cyc("R7", 1, 2, 8'h00, 0);
    cyc("R7", 1, 0, 8'd0, 0);
    for (int i = 0; i < 12; i++) cyc("R7", 0, 0, 0, 4'hF);

    // R8: write 1 keeps flag, write 0 clears, clear colliding with timeout
    cyc("R8", 1, 0, 8'd1, 4'h1);
    cyc("R8", 0, 0, 0, 4'h1);
    chk("R8", "flag set", flag_o, 1);
    cyc("R8", 1, 2, 8'h01, 0);
    cyc("R8", 1, 2, 8'h00, 0);
    chk("R8", "flag cleared", flag_o, 0);
    cyc("R8", 1, 0, 8'd2, 0);
    cyc("R8", 0, 0, 0, 4'h1);
    cyc("R8", 1, 2, 8'h00, 4'h1);
    chk("R8", "collision keeps flag", flag_o, 1);

    // R9: interrupt gating
    cyc("R9", 1, 2, 8'h03, 0);
    chk("R9", "irq on", irq_o, 1);
    cyc("R9", 1, 2, 8'h01, 0);
    chk("R9", "irq masked", irq_o, 0);
    cyc("R9", 1, 2, 8'h02, 0);
    chk("R9", "irq after clear", irq_o, 0);
    cyc("R9", 1, 0, 8'd3, 0);
    for (int i = 0; i < 4; i++) cyc("R9", 0, 0, 0, 4'h1);

    // R10: writes to address 3 ignored
    cyc("R10", 1, 0, 8'd20, 0);
    for (int i = 0; i < 4; i++) cyc("R10", 1, 3, 8'(i * 85), 4'h1);
    for (int i = 0; i < 6; i++) cyc("R10", 0, 0, 0, 4'h1);
    chk("R10", "still counting source 0", count_o, 10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule